// File: doc/BRIEF.md
# Key-Locked System Control Register Bank

This block is a bank of 32-bit system control registers that fills a 4 KB window and is addressed one 32-bit word at a time. Most locations are plain read-write storage. Writes to them are refused while the bank is locked. The lock changes state only when a 16-bit key is written to one of two dedicated key locations. Every location follows one of these access rules: read-write, read-only, write-only, or invalid. An access that breaks its location's rule raises a one-cycle error pulse.

A host drives one request per cycle on a simple port. It gives a valid strobe, a write flag, a word address and 32 bits of write data. Byte strobes do not exist, so every access covers the full word. Read data, the error pulse and the soft-reset pulse all come out of registers and appear one cycle after the request. A successful unlocked write to the reset-control word with bit 0 set also sends a single-cycle soft-reset request to the rest of the system. The current lock state is visible on an output pin and can also be read through the bank.

Top module: `keylock_ctrl_bank`

## Requirements
- R1: After reset, `locked` is 1, and `rvalid`, `acc_err` and `soft_rst_req` are 0. A read of the lock-status word (byte offset 0x00C) returns 1 in bit 0 and zeros in the other bits.
- R2: Writing 0x767B in `wdata[15:0]` to byte offset 0x004 sets `locked`. Writing 0xDF0D in `wdata[15:0]` to byte offset 0x008 clears it. Bits 31:16 are ignored. Any other value leaves `locked` unchanged. The new state is visible one cycle after the request.
- R3: Writes to 0x004 and 0x008 are accepted in either lock state, never raise `acc_err`, and store nothing.
- R4: A write to a read-write location while locked is discarded and raises `acc_err`. While unlocked, the same write is stored in full and can be read back. The read-write locations are byte offsets 0x100–0x108, 0x110–0x118, 0x120–0x16C, 0x170–0x178, 0x180–0x188, 0x190–0x198, 0x1A0–0x1A8, 0x1B8, 0x1C0, 0x1C4, 0x200–0x244, 0x24C, 0x250, 0x258, 0x300, 0x304, 0x440–0x448, 0x600, 0x61C, 0x700–0x7D4, 0x804–0x80C, 0x830, 0x834, 0x900, 0x910, 0xA00, 0xA30, 0xA50, 0xA60–0xA8C, 0xA90, 0xAA0, 0xAB0, 0xB00–0xB0C, 0xB14, 0xB18 and 0xB40–0xB74.
- R5: Byte offset 0x000 stores only `wdata[0]`, and the other bits read as 0. Writes to it are accepted without error even while the bank is locked.
- R6: A read of any write-only location raises `acc_err` and returns 0. The write-only locations are 0x004, 0x008, 0x60C and 0x614. A write to 0x60C or 0x614 stores nothing. It raises `acc_err` only while the bank is locked.
- R7: A write to a read-only location is discarded and raises `acc_err`. The read-only locations are 0x00C, 0x10C, 0x17C, 0x18C, 0x19C, 0x1AC, 0x25C, 0x530, 0x618 and 0x620. Reads of them do not raise an error. Every read-only location except 0x00C reads 0.
- R8: An unlocked write to byte offset 0x200 with `wdata[0]`=1 stores the value and pulses `soft_rst_req` for exactly one cycle, one cycle after the request. No pulse occurs when bit 0 is clear or the bank is locked.
- R9: Any offset not listed in R2–R7 is invalid. A write to it is discarded and raises `acc_err`. A read of it returns 0 and raises `acc_err`.
- R10: `rvalid` is high exactly in the cycle after a read request. `acc_err` is high only in the cycle after an offending request and is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request strobe |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 10 | Word address (byte offset bits 11:2) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with `rvalid` |
| rvalid | output | 1 | Read data valid, one cycle after a read request |
| locked | output | 1 | Current lock state |
| soft_rst_req | output | 1 | One-cycle system soft-reset request |
| acc_err | output | 1 | One-cycle access-rule violation pulse |

## Verification
Every result of a request comes out of a register and is due exactly one cycle after the request. This covers read data, the valid flag, the error pulse, the soft-reset pulse and the updated lock state. The bench drives each request on a falling edge, lets the design capture it on the next rising edge, and samples all outputs on the following falling edge. It then drops the request, so each sample belongs to exactly one access. Expected values come from a bench model that is updated only after the comparison, so every check judges the state as it stood before the access.

// File: rtl/keylock_ctrl_bank.sv
`timescale 1ns/1ps
module keylock_ctrl_bank #(
  parameter int          ADDR_W     = 10,
  parameter int          DATA_W     = 32,
  parameter logic [15:0] LOCK_KEY   = 16'h767B,
  parameter logic [15:0] UNLOCK_KEY = 16'hDF0D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              locked,
  output logic              soft_rst_req,
  output logic              acc_err
);
  localparam int DEPTH = 1 << ADDR_W;

  localparam logic [2:0] K_INV = 3'd0, K_RW = 3'd1, K_RO = 3'd2, K_WO = 3'd3,
                         K_SCL = 3'd4, K_LCK = 3'd5, K_ULK = 3'd6, K_STA = 3'd7;

  function automatic logic [2:0] kind(input logic [ADDR_W-1:0] a);
    int unsigned b;
    b = 32'(a) << 2;
    if (b == 32'h000) return K_SCL;
    if (b == 32'h004) return K_LCK;
    if (b == 32'h008) return K_ULK;
    if (b == 32'h00C) return K_STA;
    if (b inside {32'h60C, 32'h614}) return K_WO;
    if (b inside {32'h10C, 32'h17C, 32'h18C, 32'h19C, 32'h1AC,
                  32'h25C, 32'h530, 32'h618, 32'h620}) return K_RO;
    if (b inside {[32'h100:32'h108], [32'h110:32'h118], [32'h120:32'h16C],
                  [32'h170:32'h178], [32'h180:32'h188], [32'h190:32'h198],
                  [32'h1A0:32'h1A8], 32'h1B8, 32'h1C0, 32'h1C4,
                  [32'h200:32'h244], 32'h24C, 32'h250, 32'h258,
                  32'h300, 32'h304, [32'h440:32'h448], 32'h600, 32'h61C,
                  [32'h700:32'h7D4], [32'h804:32'h80C], 32'h830, 32'h834,
                  32'h900, 32'h910, 32'hA00, 32'hA30, 32'hA50,
                  [32'hA60:32'hA8C], 32'hA90, 32'hAA0, 32'hAB0,
                  [32'hB00:32'hB0C], 32'hB14, 32'hB18, [32'hB40:32'hB74]})
      return K_RW;
    return K_INV;
  endfunction

  localparam logic [ADDR_W-1:0] RST_CTRL_W = ADDR_W'(32'h200 >> 2);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [2:0]        k;
  logic              key_lo, key_ul;

  assign k      = kind(addr);
  assign key_lo = wdata[15:0] == LOCK_KEY;
  assign key_ul = wdata[15:0] == UNLOCK_KEY;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (req && we) begin
      if (k == K_SCL)
        mem[addr] <= DATA_W'(wdata[0]);
      else if (k == K_RW && !locked)
        mem[addr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked       <= 1'b1;
      rdata        <= '0;
      rvalid       <= 1'b0;
      soft_rst_req <= 1'b0;
      acc_err      <= 1'b0;
    end else begin
      rvalid       <= req && !we;
      soft_rst_req <= 1'b0;
      acc_err      <= 1'b0;
      if (req && we) begin
        case (k)
          K_LCK:   if (key_lo) locked <= 1'b1;
          K_ULK:   if (key_ul) locked <= 1'b0;
          K_SCL:   ;
          K_RW: begin
            if (locked) acc_err <= 1'b1;
            else if (addr == RST_CTRL_W && wdata[0]) soft_rst_req <= 1'b1;
          end
          K_WO:    acc_err <= locked;
          default: acc_err <= 1'b1;
        endcase
      end else if (req) begin
        rdata   <= (k == K_STA) ? DATA_W'(locked) : mem[addr];
        acc_err <= k inside {K_INV, K_WO, K_LCK, K_ULK};
      end
    end
  end
endmodule

// File: rtl/keylock_ctrl_bank_chk.sv
`timescale 1ns/1ps
module keylock_ctrl_bank_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              rvalid,
  input logic              locked,
  input logic              soft_rst_req,
  input logic              acc_err
);
  localparam logic [ADDR_W-1:0] A_LCK = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_ULK = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_STA = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_RST = ADDR_W'(32'h200 >> 2);

  logic key_wr;
  assign key_wr = req && we && (addr == A_LCK || addr == A_ULK);

  p_lock_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req && we && addr == A_LCK && wdata[15:0] == 16'h767B |=> locked);
  p_unlock_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req && we && addr == A_ULK && wdata[15:0] == 16'hDF0D |=> !locked);
  p_lock_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !key_wr |=> $stable(locked));
  p_key_no_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
    key_wr |=> !acc_err);
  p_wo_read_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req && !we && (addr == A_LCK || addr == A_ULK) |=> acc_err);
  p_ro_write_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req && we && addr == A_STA |=> acc_err);
  p_srst_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_req |-> $past(req && we && addr == A_RST && wdata[0] && !locked));
  p_rvalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req && !we |=> rvalid);
  p_err_needs_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !acc_err && !rvalid);
endmodule

bind keylock_ctrl_bank keylock_ctrl_bank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
  .rvalid(rvalid), .locked(locked), .soft_rst_req(soft_rst_req), .acc_err(acc_err)
);

// File: tb/sim_keylock_ctrl_bank.sv
`timescale 1ns/1ps
module sim_keylock_ctrl_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid, locked, soft_rst_req, acc_err;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] m_mem [1024];
  logic        m_lock;

  always #4 clk = ~clk;

  keylock_ctrl_bank u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rvalid(rvalid), .locked(locked),
    .soft_rst_req(soft_rst_req), .acc_err(acc_err)
  );

  // 0 invalid, 1 rw, 2 ro, 3 wo-trigger, 4 bit0 word, 5 lock, 6 unlock, 7 status
  function automatic int cls(input int b);
    if (b == 'h000) return 4;
    if (b == 'h004) return 5;
    if (b == 'h008) return 6;
    if (b == 'h00C) return 7;
    if (b == 'h60C || b == 'h614) return 3;
    if (b == 'h10C || b == 'h17C || b == 'h18C || b == 'h19C || b == 'h1AC ||
        b == 'h25C || b == 'h530 || b == 'h618 || b == 'h620) return 2;
    if ((b >= 'h100 && b <= 'h108) || (b >= 'h110 && b <= 'h118) ||
        (b >= 'h120 && b <= 'h16C) || (b >= 'h170 && b <= 'h178) ||
        (b >= 'h180 && b <= 'h188) || (b >= 'h190 && b <= 'h198) ||
        (b >= 'h1A0 && b <= 'h1A8) || b == 'h1B8 || b == 'h1C0 || b == 'h1C4 ||
        (b >= 'h200 && b <= 'h244) || b == 'h24C || b == 'h250 || b == 'h258 ||
        b == 'h300 || b == 'h304 || (b >= 'h440 && b <= 'h448) ||
        b == 'h600 || b == 'h61C || (b >= 'h700 && b <= 'h7D4) ||
        (b >= 'h804 && b <= 'h80C) || b == 'h830 || b == 'h834 ||
        b == 'h900 || b == 'h910 || b == 'hA00 || b == 'hA30 || b == 'hA50 ||
        (b >= 'hA60 && b <= 'hA8C) || b == 'hA90 || b == 'hAA0 || b == 'hAB0 ||
        (b >= 'hB00 && b <= 'hB0C) || b == 'hB14 || b == 'hB18 ||
        (b >= 'hB40 && b <= 'hB74)) return 1;
    return 0;
  endfunction

  function automatic logic exp_err(input logic w, input int c, input logic lk);
    if (w) return (c == 0 || c == 2 || c == 7 || ((c == 1 || c == 3) && lk));
    return (c == 0 || c == 3 || c == 5 || c == 6);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic w, input int b, input logic [31:0] d);
    int          c = cls(b);
    logic        e_err = exp_err(w, c, m_lock);
    logic        e_srst = w && c == 1 && !m_lock && b == 'h200 && d[0];
    logic [31:0] e_rd = (c == 7) ? {31'b0, m_lock} : m_mem[b >> 2];
    logic        n_lock = m_lock;
    if (w && c == 5 && d[15:0] == 16'h767B) n_lock = 1'b1;
    if (w && c == 6 && d[15:0] == 16'hDF0D) n_lock = 1'b0;
    @(negedge clk);
    req = 1'b1; we = w; addr = 10'(b >> 2); wdata = d;
    @(negedge clk);
    req = 1'b0;
    check("R10 rvalid", 32'(rvalid), 32'(!w));
    check(c == 0 ? "R9 err" : (c == 3 || c == 5 || c == 6) ? "R6/R3 err" :
          c == 2 ? "R7 err" : "R4 err", 32'(acc_err), 32'(e_err));
    check("R8 soft reset", 32'(soft_rst_req), 32'(e_srst));
    check("R2 lock state", 32'(locked), 32'(n_lock));
    if (!w) check(c == 0 ? "R9 read" : c == 4 ? "R5 read" : "R4 read", rdata, e_rd);
    if (w && c == 4) m_mem[0] = {31'b0, d[0]};
    if (w && c == 1 && !m_lock) m_mem[b >> 2] = d;
    m_lock = n_lock;
    @(negedge clk);
    check("R10 err pulse", 32'(acc_err), 32'd0);
    check("R8 single pulse", 32'(soft_rst_req), 32'd0);
  endtask

  function automatic int pick_addr();
    int s = int'($urandom_range(0, 19));
    case (s)
      0: return 'h000;  1: return 'h004;  2: return 'h008;  3: return 'h00C;
      4: return 'h10C;  5: return 'h200;  6: return 'h25C;  7: return 'h60C;
      8: return 'h614;  9: return 'h7D4; 10: return 'h7D8; 11: return 'hB74;
      12: return 'hB78; 13: return 'h100; 14: return 'hA8C; 15: return 'h530;
      default: return int'($urandom_range(0, 1023)) << 2;
    endcase
  endfunction

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    for (int i = 0; i < 1024; i++) m_mem[i] = '0;
    m_lock = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 locked", 32'(locked), 32'd1);
    check("R1 rvalid", 32'(rvalid), 32'd0);
    check("R1 err", 32'(acc_err), 32'd0);
    check("R1 srst", 32'(soft_rst_req), 32'd0);
    access(1'b0, 'h00C, 0);
    // R4 locked write rejected, R5 bit0 word while locked
    access(1'b1, 'h100, 32'hCAFE_F00D);
    access(1'b0, 'h100, 0);
    access(1'b1, 'h000, 32'hFFFF_FFFF);
    access(1'b0, 'h000, 0);
    // R2 wrong key, upper bits ignored
    access(1'b1, 'h008, 32'h0000_DF0C);
    access(1'b1, 'h008, 32'hABCD_DF0D);
    access(1'b0, 'h00C, 0);
    access(1'b1, 'h100, 32'hCAFE_F00D);
    access(1'b0, 'h100, 0);
    // R8 soft reset cases
    access(1'b1, 'h200, 32'h0000_0001);
    access(1'b1, 'h200, 32'h0000_0002);
    access(1'b0, 'h200, 0);
    // R6, R7, R9
    access(1'b0, 'h60C, 0);
    access(1'b1, 'h614, 32'h1);
    access(1'b1, 'h530, 32'h1234);
    access(1'b0, 'h530, 0);
    access(1'b1, 'hFFC, 32'h55);
    access(1'b0, 'hFFC, 0);
    access(1'b1, 'h004, 32'h0000_767B);
    access(1'b1, 'h200, 32'h1);
    access(1'b1, 'h614, 32'h1);
    for (int n = 0; n < 3000; n++) begin
      int          b = pick_addr();
      logic        w = 1'($urandom_range(0, 1));
      logic [31:0] d = $urandom;
      int          r = int'($urandom_range(0, 3));
      if (r == 0 && b == 'h004) d[15:0] = 16'h767B;
      if (r <= 1 && b == 'h008) d[15:0] = 16'hDF0D;
      access(w, b, d);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule